// File: doc/BRIEF.md
# Cache Fill Permission Gate

This block sits between a cache's lookup path and the bus unit and decides, per access and per bus cycle, whether a cache lookup takes place and whether a miss is allowed to allocate a line. Lookups always proceed, whatever the software mode. Turning the cache off freezes its contents. It does not bypass them, so a line that was never invalidated can still hit.

On a miss the block starts a bus cycle and works out an internal vote. The vote is set only when the software cache-off bit, the locked-operation flag, the table-walk flag and the page no-cache attribute are all clear. The external enable input is then sampled on the first data-ready beat. The cycle becomes a multi-beat line fill only if the internal vote and the sampled external enable are both set. Otherwise it ends as a single transfer that allocates nothing. The two software mode bits are captured when an access is accepted and stay frozen until that access's bus cycle has finished.

Top module: `cache_fill_gate`

## Requirements
- R1: `lookup_en` equals `acc_valid` whenever `busy` is low, for any value of `cfg_cache_off`; while `busy` is high, `lookup_en` is 0.
- R2: An accepted access with `acc_miss`=1 raises `busy` at the next clock edge. While the block waits for the first beat, `bus_cache_req` shows the internal vote: 1 exactly when cache-off, locked, walk and page no-cache were all 0 at acceptance.
- R3: With `cfg_cache_off`=1 at acceptance, no `fill_we` pulse occurs and the cycle ends on its first beat.
- R4: A locked access (`acc_locked`=1) never allocates: no `fill_we` pulse, and the cycle is single-beat.
- R5: A table-walk read (`acc_walk`=1) never allocates and is single-beat.
- R6: An access with `acc_page_nc`=1 never allocates and is single-beat.
- R7: `bus_ken` is sampled only on the first `bus_rdy` of the cycle. If it is 0 there, `xfer_done` pulses on that beat, no `fill_we` occurs, and `busy` drops at the next edge.
- R8: In a line fill, every one of the `BEATS` data beats (default 4) raises `fill_we`, even when `bus_ken` changes after the first beat. `xfer_done` pulses on the `BEATS`-th `bus_rdy`, and `line_fill` is 1 from the edge after the first beat until the edge after the last.
- R9: `mode_cache_off` and `mode_no_wt` take the `cfg_cache_off` and `cfg_no_wt` values present at acceptance. They do not change while `busy` is high and follow the new settings only from the next accepted access.
- R10: An accepted access with `acc_miss`=0 (a hit) starts no bus cycle, and `busy` stays 0.
- R11: After reset, `busy`, `line_fill`, `bus_cache_req`, `mode_cache_off` and `mode_no_wt` are 0.
- R12: `bus_rdy` while `busy` is 0 has no effect: `fill_we` and `xfer_done` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_cache_off | input | 1 | Software cache-disable bit |
| cfg_no_wt | input | 1 | Software no-write-through bit |
| acc_valid | input | 1 | Access presented this cycle |
| acc_miss | input | 1 | Lookup result was a miss |
| acc_locked | input | 1 | Access is part of a locked operation |
| acc_walk | input | 1 | Access is a page-table walk read |
| acc_page_nc | input | 1 | Page attribute forbids caching |
| bus_rdy | input | 1 | Data-ready strobe for one beat |
| bus_ken | input | 1 | External cache-enable vote |
| lookup_en | output | 1 | Lookup of the arrays enabled |
| busy | output | 1 | Bus cycle in progress |
| bus_cache_req | output | 1 | Internal vote offered to the bus unit |
| line_fill | output | 1 | Current cycle is a line fill |
| fill_we | output | 1 | Write this beat into the line |
| xfer_done | output | 1 | Last beat of the bus cycle |
| mode_cache_off | output | 1 | Cache-off bit held for the current access |
| mode_no_wt | output | 1 | No-write-through bit held for the current access |

## Verification
`lookup_en`, `fill_we` and `xfer_done` are combinational and are due in the same cycle as the input that causes them. The bench samples them one time unit after it drives inputs at the falling edge, before the next rising edge. `busy`, `bus_cache_req`, the mode outputs and the start of `line_fill` change at the first rising edge after their cause, so the bench checks them at the following falling edge. `line_fill` and `busy` clear at the edge after the last beat, and the bench checks them at the falling edge that follows.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_BURST = 2'd2
  } cc_state_e;

  // internal cacheability vote: every veto must be clear
  function automatic logic fill_vote(input logic cache_off, input logic locked,
                                     input logic walk, input logic page_nc);
    return !(cache_off || locked || walk || page_nc);
  endfunction

  // final decision at the first beat
  function automatic logic line_decide(input logic vote, input logic ken);
    return vote && ken;
  endfunction
endpackage

// File: rtl/cc_mode_snap.sv
module cc_mode_snap (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic cache_off_in,
  input  logic no_wt_in,
  output logic cache_off_q,
  output logic no_wt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cache_off_q <= 1'b0;
      no_wt_q     <= 1'b0;
    end else if (load) begin
      cache_off_q <= cache_off_in;
      no_wt_q     <= no_wt_in;
    end
  end
endmodule

// File: rtl/cc_vote.sv
module cc_vote
  import cc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic cache_off,
  input  logic locked,
  input  logic walk,
  input  logic page_nc,
  output logic vote_now,
  output logic vote_q
);
  assign vote_now = fill_vote(cache_off, locked, walk, page_nc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vote_q <= 1'b0;
    else if (load) vote_q <= vote_now;
  end
endmodule

// File: rtl/cc_burst_fsm.sv
module cc_burst_fsm
  import cc_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic vote_q,
  input  logic bus_rdy,
  input  logic bus_ken,
  output logic busy,
  output logic addr_phase,
  output logic first_beat,
  output logic line_fill,
  output logic fill_we,
  output logic xfer_done
);
  localparam int CW = (BEATS > 2) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  cc_state_e      state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           line_q, line_d;
  logic           take_line;
  logic           last_beat;

  assign addr_phase = (state_q == ST_ADDR);
  assign first_beat = addr_phase && bus_rdy;
  assign take_line  = line_decide(vote_q, bus_ken);
  assign last_beat  = (state_q == ST_BURST) && bus_rdy && (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    line_d  = line_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_ADDR;
          cnt_d   = '0;
          line_d  = 1'b0;
        end
      end
      ST_ADDR: begin
        if (bus_rdy) begin
          if (take_line) begin
            state_d = ST_BURST;
            cnt_d   = CW'(1);
            line_d  = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_BURST: begin
        if (bus_rdy) begin
          if (cnt_q == LAST) begin
            state_d = ST_IDLE;
            line_d  = 1'b0;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        line_d  = 1'b0;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      line_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      line_q  <= line_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign line_fill = line_q;
  assign fill_we   = (first_beat && take_line) || ((state_q == ST_BURST) && bus_rdy);
  assign xfer_done = (first_beat && !take_line) || last_beat;
endmodule

// File: rtl/cache_fill_gate.sv
module cache_fill_gate
  import cc_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_cache_off,
  input  logic cfg_no_wt,
  input  logic acc_valid,
  input  logic acc_miss,
  input  logic acc_locked,
  input  logic acc_walk,
  input  logic acc_page_nc,
  input  logic bus_rdy,
  input  logic bus_ken,
  output logic lookup_en,
  output logic busy,
  output logic bus_cache_req,
  output logic line_fill,
  output logic fill_we,
  output logic xfer_done,
  output logic mode_cache_off,
  output logic mode_no_wt
);
  logic accept;
  logic start_miss;
  logic vote_now;
  logic vote_q;
  logic addr_phase;
  logic first_beat;
  logic busy_w;

  // blocking cache: a new lookup waits for the previous bus cycle
  assign accept     = acc_valid && !busy_w;
  assign start_miss = accept && acc_miss;
  assign lookup_en  = accept;

  cc_mode_snap u_snap (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (accept),
    .cache_off_in (cfg_cache_off),
    .no_wt_in     (cfg_no_wt),
    .cache_off_q  (mode_cache_off),
    .no_wt_q      (mode_no_wt)
  );

  cc_vote u_vote (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_miss),
    .cache_off (cfg_cache_off),
    .locked    (acc_locked),
    .walk      (acc_walk),
    .page_nc   (acc_page_nc),
    .vote_now  (vote_now),
    .vote_q    (vote_q)
  );

  cc_burst_fsm #(.BEATS(BEATS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_miss),
    .vote_q     (vote_q),
    .bus_rdy    (bus_rdy),
    .bus_ken    (bus_ken),
    .busy       (busy_w),
    .addr_phase (addr_phase),
    .first_beat (first_beat),
    .line_fill  (line_fill),
    .fill_we    (fill_we),
    .xfer_done  (xfer_done)
  );

  assign busy          = busy_w;
  assign bus_cache_req = addr_phase && vote_q;
endmodule

// File: rtl/cache_fill_gate_chk.sv
module cache_fill_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic acc_valid,
  input logic acc_miss,
  input logic bus_rdy,
  input logic bus_ken,
  input logic lookup_en,
  input logic busy,
  input logic line_fill,
  input logic fill_we,
  input logic xfer_done,
  input logic mode_cache_off,
  input logic mode_no_wt
);
  // R1
  lookup_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !lookup_en);
  // R2
  miss_starts_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_en && acc_miss) |=> busy);
  // R10
  hit_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_en && !acc_miss) |=> !busy);
  // R12
  idle_rdy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(fill_we || xfer_done));
  // R7
  fill_needs_ken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_fill) |-> $past(bus_rdy && bus_ken && fill_we));
  // R8
  burst_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_fill |-> (fill_we == bus_rdy));
  // R7
  done_ends_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !busy);
  // R9
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mode_cache_off) && $stable(mode_no_wt)));
endmodule

bind cache_fill_gate cache_fill_gate_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .acc_valid      (acc_valid),
  .acc_miss       (acc_miss),
  .bus_rdy        (bus_rdy),
  .bus_ken        (bus_ken),
  .lookup_en      (lookup_en),
  .busy           (busy),
  .line_fill      (line_fill),
  .fill_we        (fill_we),
  .xfer_done      (xfer_done),
  .mode_cache_off (mode_cache_off),
  .mode_no_wt     (mode_no_wt)
);

// File: tb/cache_fill_gate_test.sv
module cache_fill_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int BEATS = 4;
  localparam int NVEC = 10;
  // {cache_off, locked, walk, page_nc, ken}
  localparam logic [4:0] VEC [NVEC] = '{
    5'b00001, 5'b00000, 5'b10001, 5'b01001, 5'b00101,
    5'b00011, 5'b11111, 5'b00001, 5'b10000, 5'b01100
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cache_off = 0, cfg_no_wt = 0, acc_valid = 0, acc_miss = 0;
  logic acc_locked = 0, acc_walk = 0, acc_page_nc = 0, bus_rdy = 0, bus_ken = 0;
  logic lookup_en, busy, bus_cache_req, line_fill, fill_we, xfer_done;
  logic mode_cache_off, mode_no_wt;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_fill_gate #(.BEATS(BEATS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_cache_off(cfg_cache_off), .cfg_no_wt(cfg_no_wt),
    .acc_valid(acc_valid), .acc_miss(acc_miss), .acc_locked(acc_locked),
    .acc_walk(acc_walk), .acc_page_nc(acc_page_nc), .bus_rdy(bus_rdy),
    .bus_ken(bus_ken), .lookup_en(lookup_en), .busy(busy),
    .bus_cache_req(bus_cache_req), .line_fill(line_fill), .fill_we(fill_we),
    .xfer_done(xfer_done), .mode_cache_off(mode_cache_off), .mode_no_wt(mode_no_wt)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // present one access for one cycle; leaves the bench at the next falling edge
  task automatic present(input logic cd, input logic nw, input logic lk,
                         input logic wk, input logic pc, input logic miss);
    @(negedge clk);
    cfg_cache_off = cd; cfg_no_wt = nw; acc_locked = lk; acc_walk = wk;
    acc_page_nc = pc; acc_miss = miss; acc_valid = 1;
    #1 chk("R1 lookup_en", lookup_en, 1'b1);
    @(negedge clk);
    acc_valid = 0; acc_locked = 0; acc_walk = 0; acc_page_nc = 0; acc_miss = 0;
  endtask

  // run beats until done; ken on first beat, inverted on later beats
  task automatic run_beats(input logic ken, output int nwe, output int nbeats);
    nwe = 0; nbeats = 0;
    for (int i = 0; i < 2*BEATS; i++) begin
      bus_rdy = 1; bus_ken = (i == 0) ? ken : ~ken;
      #1;
      nbeats++;
      if (fill_we) nwe++;
      if (xfer_done) begin
        @(negedge clk); bus_rdy = 0; bus_ken = 0;
        break;
      end
      @(negedge clk);
    end
    bus_rdy = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int nwe, nb;
    logic vote, exp_line;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0); chk("R11 line_fill", line_fill, 0);
    chk("R11 bus_cache_req", bus_cache_req, 0);
    chk("R11 mode_cache_off", mode_cache_off, 0); chk("R11 mode_no_wt", mode_no_wt, 0);
    rst_n = 1;
    @(negedge clk);
    // R12 rdy while idle
    bus_rdy = 1; bus_ken = 1; #1;
    chk("R12 fill_we", fill_we, 0); chk("R12 xfer_done", xfer_done, 0);
    @(negedge clk); bus_rdy = 0; bus_ken = 0; #1;
    chk("R12 busy", busy, 0);

    // vector table: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      vote = !(VEC[v][4] || VEC[v][3] || VEC[v][2] || VEC[v][1]);
      exp_line = vote && VEC[v][0];
      present(VEC[v][4], 1'b0, VEC[v][3], VEC[v][2], VEC[v][1], 1'b1);
      chk("R2 busy", busy, 1);
      chk("R2 bus_cache_req", bus_cache_req, vote);
      run_beats(VEC[v][0], nwe, nb);
      chk("R3-R8 line writes", nwe == (exp_line ? BEATS : 0), 1'b1);
      chk("R7 R8 beat count", nb == (exp_line ? BEATS : 1), 1'b1);
      chk("R7 busy after", busy, 0);
      chk("R8 line_fill after", line_fill, 0);
    end

    // R1 lookup with cache off, R10 hit
    present(1, 0, 0, 0, 0, 0);
    chk("R10 busy on hit", busy, 0);
    chk("R9 mode_cache_off", mode_cache_off, 1);

    // R8 line_fill timing and R9 freeze
    present(0, 1, 0, 0, 0, 1);
    chk("R9 mode_no_wt", mode_no_wt, 1);
    cfg_cache_off = 1; cfg_no_wt = 0;
    acc_valid = 1; #1;
    chk("R1 lookup blocked busy", lookup_en, 0);
    bus_rdy = 1; bus_ken = 1; #1;
    chk("R8 first fill_we", fill_we, 1);
    @(negedge clk); acc_valid = 0; #1;
    chk("R8 line_fill rises", line_fill, 1);
    chk("R9 frozen cache_off", mode_cache_off, 0);
    chk("R9 frozen no_wt", mode_no_wt, 1);
    for (int i = 1; i < BEATS; i++) begin
      bus_ken = 0; #1;
      chk("R8 beat fill_we", fill_we, 1);
      chk("R8 done on last", xfer_done, (i == BEATS-1));
      @(negedge clk);
    end
    bus_rdy = 0; #1;
    chk("R8 line_fill clears", line_fill, 0);
    chk("R8 busy clears", busy, 0);
    present(cfg_cache_off, cfg_no_wt, 0, 0, 0, 0);
    chk("R9 new cache_off", mode_cache_off, 1);
    chk("R9 new no_wt", mode_no_wt, 0);
    // R3 cache off miss with ken high
    present(1, 0, 0, 0, 0, 1);
    run_beats(1, nwe, nb);
    chk("R3 no alloc", nwe == 0, 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule